// File: doc/BRIEF.md
# Serial ADC Host Interface with Control Register

This block is the digital host-side front end of a 12-bit, two-input successive-approximation converter. A host frames each transfer with an active-low select and a serial clock. During one frame the block shifts in an 8-bit control word on the data input. At the same time it shifts out, on the data output, the result of the previous conversion as a 16-bit word.

The control word chooses the reference source, single or dual input operation, the input channel and one of four power modes. These fields are decoded onto plain outputs for the analog side. When the select falls, the block pulses a start strobe to a converter model and gives it the effective channel. The model returns each 12-bit result over a parallel port with a valid strobe. The block keeps the newest result and serves it in the next frame.

The serial pins are oversampled by a system clock that is much faster than the serial clock. If the host holds the data input low, the block behaves as a read-only, single-input device.

Top module: `serial_adc_front`

## Requirements
- R1: After reset the control register is all zeros. ref_off, dual_mode and chan_sel are 0, pwr_mode is 0 and dout_oe is 0.
- R2: Control bits are sampled on serial clock rising edges, MSB first. In the received word, bit 5 drives ref_off, bit 4 drives dual_mode, bit 3 is the channel bit and bits 1:0 drive pwr_mode. Bits 7, 6 and 2 have no effect on any output.
- R3: Only the first eight rising edges after the select falls write the control register. Data on rising edges 9 to 16 has no effect.
- R4: A new control word takes effect only when its eighth bit has been received. A frame that ends after fewer than eight rising edges leaves all decoded outputs unchanged, and the decoded outputs never change while the select is high.
- R5: The output word is 16 bits: four zeros, then the 12-bit straight-binary result with its MSB first. Word bit 15 is on dout before the first serial clock edge, and each serial clock falling edge moves dout to the next lower bit.
- R6: res_data is captured whenever res_valid is 1. A frame returns the last result captured before its select fell, and this result is 0 if none has been captured since reset.
- R7: dout_oe is 0 while the select is high and 1 while it is low. When dout_oe is 0, the dout pad is to be left undriven (high-impedance).
- R8: Each falling edge of the select gives exactly one one-cycle conv_start pulse. conv_chan carries the effective channel from the control register in force at that time.
- R9: A frame with the data input held low loads all zeros: internal reference on (ref_off 0), single-input mode and power mode 0.
- R10: The effective channel chan_sel is 1 only when both dual_mode and the channel bit are 1. In single-input mode it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial control data, MSB first |
| dout | output | 1 | Serial result data, MSB first |
| dout_oe | output | 1 | Output enable for the dout pad driver |
| conv_start | output | 1 | One-cycle request to start a conversion |
| conv_chan | output | 1 | Channel for the requested conversion |
| res_valid | input | 1 | Result strobe from the converter model |
| res_data | input | 12 | Conversion result, straight binary |
| ref_off | output | 1 | 1 disables the internal reference |
| dual_mode | output | 1 | 1 selects dual-input operation |
| chan_sel | output | 1 | Effective input channel |
| pwr_mode | output | 2 | Power mode field |

## Verification
The main function is tried with several frame patterns, and each separates a different fault:
- A word with the don't-care and must-be-zero bits set, followed by late bits held at 1, shows whether field decoding uses the right bit positions and whether the write window closes after eight edges.
- Frames aborted after five and seven edges show whether the register commits only on the eighth bit.
- A single-input word with the channel bit set shows the channel masking.
- A frame with the data input held low shows the read-only default.

Results that alternate between complementary bit patterns, all ones and a lone LSB expose any shift, ordering or padding error in the returned word. The start strobe's channel is compared against the configuration that was in force at each select fall.

// File: rtl/serial_adc_front.sv
module serial_adc_front #(
  parameter int RES_W  = 12,
  parameter int PAD_W  = 4,
  parameter int CTRL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             din,
  output logic             dout,
  output logic             dout_oe,
  output logic             conv_start,
  output logic             conv_chan,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_data,
  output logic             ref_off,
  output logic             dual_mode,
  output logic             chan_sel,
  output logic [1:0]       pwr_mode
);
  localparam int FRAME_W = PAD_W + RES_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int B_REF   = 5;
  localparam int B_DUAL  = 4;
  localparam int B_CH    = 3;

  logic s_cs, p_cs, s_sclk, p_sclk, s_din;
  logic [CNT_W-1:0]   bit_cnt;
  logic [CTRL_W-2:0]  rx_sh;
  logic [CTRL_W-1:0]  word;
  logic               ref_q, dual_q, ch_q;
  logic [1:0]         pm_q;
  logic [RES_W-1:0]   res_q;
  logic [FRAME_W-1:0] tx_sh;
  logic               sel, cs_fall, sc_rise, sc_fall, last_ctrl;
  logic               unused_bits;

  assign sel       = ~s_cs;
  assign cs_fall   = p_cs & ~s_cs;
  assign sc_rise   = sel & s_sclk & ~p_sclk;
  assign sc_fall   = sel & ~s_sclk & p_sclk;
  assign word      = {rx_sh, s_din};
  assign last_ctrl = sc_rise && (bit_cnt == CNT_W'(CTRL_W - 1));
  assign unused_bits = ^{word[CTRL_W-1], word[CTRL_W-2], word[2]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_cs   <= 1'b1;
      p_cs   <= 1'b1;
      s_sclk <= 1'b0;
      p_sclk <= 1'b0;
      s_din  <= 1'b0;
    end else begin
      s_cs   <= cs_n;
      p_cs   <= s_cs;
      s_sclk <= sclk;
      p_sclk <= s_sclk;
      s_din  <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || s_cs)
      bit_cnt <= '0;
    else if (sc_rise && bit_cnt != CNT_W'(FRAME_W))
      bit_cnt <= bit_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rx_sh <= '0;
    else if (sc_rise && bit_cnt < CNT_W'(CTRL_W))
      rx_sh <= word[CTRL_W-2:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q  <= 1'b0;
      dual_q <= 1'b0;
      ch_q   <= 1'b0;
      pm_q   <= 2'b00;
    end else if (last_ctrl) begin
      ref_q  <= word[B_REF];
      dual_q <= word[B_DUAL];
      ch_q   <= word[B_CH];
      pm_q   <= word[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      res_q <= '0;
    else if (res_valid)
      res_q <= res_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      tx_sh <= '0;
    else if (s_cs)
      tx_sh <= {{PAD_W{1'b0}}, res_q};
    else if (sc_fall)
      tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
  end

  assign ref_off    = ref_q;
  assign dual_mode  = dual_q;
  assign chan_sel   = dual_q & ch_q;
  assign pwr_mode   = pm_q;
  assign dout       = tx_sh[FRAME_W-1];
  assign dout_oe    = sel;
  assign conv_start = cs_fall;
  assign conv_chan  = chan_sel;
endmodule

module serial_adc_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       dout,
  input logic       dout_oe,
  input logic       conv_start,
  input logic       ref_off,
  input logic       dual_mode,
  input logic       chan_sel,
  input logic [1:0] pwr_mode
);
  a_r7_oe_off_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> !dout_oe);

  a_r4_cfg_hold_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |=> $stable({ref_off, dual_mode, chan_sel, pwr_mode}));

  a_r8_start_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  a_r5_first_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_oe) |-> !dout);

  a_r10_single_chan_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_mode |-> !chan_sel);
endmodule

bind serial_adc_front serial_adc_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dout(dout), .dout_oe(dout_oe),
  .conv_start(conv_start), .ref_off(ref_off), .dual_mode(dual_mode),
  .chan_sel(chan_sel), .pwr_mode(pwr_mode)
);

// File: tb/sim_serial_adc_front.sv
module sim_serial_adc_front;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic        res_valid = 1'b0;
  logic [11:0] res_data = '0;
  logic        dout, dout_oe, conv_start, conv_chan;
  logic        ref_off, dual_mode, chan_sel;
  logic [1:0]  pwr_mode;

  serial_adc_front u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .dout(dout), .dout_oe(dout_oe), .conv_start(conv_start), .conv_chan(conv_chan),
    .res_valid(res_valid), .res_data(res_data), .ref_off(ref_off),
    .dual_mode(dual_mode), .chan_sel(chan_sel), .pwr_mode(pwr_mode)
  );

  int checks = 0, failures = 0;
  logic [15:0] exp_q[$];
  logic [15:0] rd_word;
  event frame_done;

  logic       m_ref = 0, m_dual = 0, m_ch = 0;
  logic [1:0] m_pm = 0;
  logic [11:0] last_res = '0;
  int pend = 0, seq = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] code(input int n);
    case (n % 4)
      0: code = 12'hA5A;
      1: code = 12'h5A5;
      2: code = 12'hFFF;
      default: code = 12'h001;
    endcase
  endfunction

  initial forever begin
    @(negedge clk);
    res_valid = 1'b0;
    if (rst_n && conv_start) begin
      chk(conv_chan == (m_dual & m_ch), "R8 conv_chan at start", conv_chan, m_dual & m_ch);
      pend = 20;
    end
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        res_data  = code(seq);
        res_valid = 1'b1;
        last_res  = code(seq);
        seq++;
      end
    end
  end

  initial forever begin
    @(frame_done);
    if (exp_q.size() > 0) begin
      logic [15:0] e;
      e = exp_q.pop_front();
      chk(rd_word == e, "R5 R6 read word", rd_word, e);
    end
  end

  task automatic cfg_chk(input string tag);
    chk({ref_off, dual_mode, chan_sel, pwr_mode} == {m_ref, m_dual, m_dual & m_ch, m_pm},
        tag, {ref_off, dual_mode, chan_sel, pwr_mode}, {m_ref, m_dual, m_dual & m_ch, m_pm});
  endtask

  task automatic xfer(input logic [7:0] ctl, input int nbits, input logic late);
    int starts_seen;
    if (nbits == 16) exp_q.push_back({4'h0, last_res});
    @(negedge clk) cs_n = 1'b0;
    starts_seen = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (conv_start) starts_seen++;
    end
    chk(starts_seen == 1, "R8 one start pulse", starts_seen, 1);
    chk(dout_oe == 1'b1, "R7 oe during frame", dout_oe, 1);
    for (int i = 0; i < nbits; i++) begin
      rd_word[15-i] = dout;
      din = (i < 8) ? ctl[7-i] : late;
      repeat (2) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
    end
    din = 1'b0;
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(dout_oe == 1'b0, "R7 oe after frame", dout_oe, 0);
    if (nbits >= 8) begin
      m_ref = ctl[5]; m_dual = ctl[4]; m_ch = ctl[3]; m_pm = ctl[1:0];
    end
    if (nbits == 16) begin
      ->frame_done;
      @(negedge clk);
    end
  endtask

  initial begin
    #2000000;
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cfg_chk("R1 reset config zero");
    chk(dout_oe == 1'b0, "R1 R7 oe at reset", dout_oe, 0);

    xfer(8'h00, 16, 1'b0);
    cfg_chk("R9 read-only defaults");

    xfer(8'hBA, 16, 1'b1);
    cfg_chk("R2 R3 decode with late ones");
    chk(chan_sel == 1'b1, "R2 dual chan1", chan_sel, 1);

    xfer(8'h45, 16, 1'b1);
    cfg_chk("R2 ignored bits 6 and 2");
    chk(pwr_mode == 2'd1, "R2 pwr mode", pwr_mode, 1);

    xfer(8'h18, 16, 1'b1);
    cfg_chk("R2 dual chan1 again");

    xfer(8'h08, 16, 1'b1);
    cfg_chk("R10 single masks chan");
    chk(chan_sel == 1'b0, "R10 chan_sel zero", chan_sel, 0);

    xfer(8'hFF, 5, 1'b1);
    cfg_chk("R4 abort after 5");
    xfer(8'h3F, 7, 1'b1);
    cfg_chk("R4 abort after 7");

    xfer(8'h13, 16, 1'b1);
    cfg_chk("R2 dual chan0 pm3");
    xfer(8'h38, 16, 1'b1);
    cfg_chk("R2 ref off dual chan1");
    xfer(8'h00, 16, 1'b0);
    cfg_chk("R9 back to defaults");
    xfer(8'h00, 16, 1'b0);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all frames compared", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule